// File: doc/BRIEF.md
# Serial Presence Detect Parser

This block fetches the first 64 bytes of a memory module's presence-detect EEPROM through a simple byte-read request interface. It then turns the contents into a set of registered configuration values for a memory controller. An external two-wire bus master serves each request and answers with a one-cycle acknowledge that carries the data byte. The parser issues one request at a time, in ascending address order. It keeps a running modulo-256 sum of the bytes as they arrive and captures the fields it needs on the fly.

When the last byte has been accepted, the parser checks the stored checksum and the memory-type code. It copies the decoded geometry and timing fields to its outputs and picks the lowest usable CAS latency for the target clock period. It then raises `done`, together with `err` if the image is not valid. A controller pulses `start` once after reset, or after a module change, and waits for `done` before it programs its timing.

Top module: `spd_parser`

## Requirements
- R1: After reset, `rd_req`, `done`, `err`, `cas_lat` and every configuration output are zero.
- R2: A `start` pulse while no fetch is running begins a new fetch at address 0 and clears `done` and `err` in the next cycle. A `start` pulse during a fetch has no effect on the address sequence or the results.
- R3: Addresses 0 to 63 are requested in ascending order, one at a time. `rd_req` stays high and `rd_addr` stays stable until `rd_ack` is high, and `rd_data` is taken only in a cycle with `rd_ack` high.
- R4: `done` rises in the cycle after byte 63 is acknowledged, and `rd_req` falls in that same cycle. `done` then stays high until the next accepted `start`.
- R5: `err` is set with `done` when byte 63 differs from the sum of bytes 0 to 62 modulo 256.
- R6: `err` is set with `done` when byte 2 (memory type) is not 0x04.
- R7: The geometry outputs are taken from fixed bytes:
  - `row_count` is byte 3 and `col_count` is byte 4.
  - `rank_count` is byte 5.
  - `data_width` is {byte 7, byte 6}, so 0x0040 means 64 bits and 0x0048 means 72 bits.
  - `ecc_en` is 1 exactly when byte 11 equals 0x02.
- R8: The timing outputs keep the encodings stored in the image:
  - `tck_cl3` is byte 9 and `tac_cl3` is byte 10.
  - `tck_cl2` is byte 23 and `tac_cl2` is byte 24.
  - `trp_ns` is byte 27, `trcd_ns` is byte 29 and `tras_ns` is byte 30.
  - Cycle and access times use the high nibble for whole ns and the low nibble for tenths. The last three are whole ns.
- R9: `self_refresh` is bit 7 of byte 12, and `refresh_code` is bits 6:0 of byte 12 (0x82 gives 1 and 0x02). `cl_support` is byte 18, in which bit n set means CAS latency n+1 is supported.
- R10: `cas_lat` is 2 when bit 1 of byte 18 is set and byte 23 is no larger than `target_tck`, compared as unsigned 8-bit values in the same nibble encoding. Otherwise `cas_lat` is 3.
- R11: The configuration outputs and `cas_lat` change only in the cycle `done` rises. They keep their previous values while a fetch runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch (ignored while one runs) |
| target_tck | input | 8 | Controller clock period, high nibble ns, low nibble tenths |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 6 | Byte address requested |
| rd_ack | input | 1 | Request served; rd_data valid this cycle |
| rd_data | input | 8 | Byte read from the EEPROM |
| done | output | 1 | Fetch and decode complete |
| err | output | 1 | Checksum or memory-type mismatch |
| row_count | output | 8 | Row address bits |
| col_count | output | 8 | Column address bits |
| rank_count | output | 8 | Number of ranks |
| data_width | output | 16 | Module data width in bits |
| ecc_en | output | 1 | Module carries check bits |
| tck_cl3 | output | 8 | Minimum cycle time at CL3 |
| tac_cl3 | output | 8 | Access time at CL3 |
| tck_cl2 | output | 8 | Minimum cycle time at CL2 |
| tac_cl2 | output | 8 | Access time at CL2 |
| trp_ns | output | 8 | Minimum precharge time, ns |
| trcd_ns | output | 8 | Minimum row-to-column delay, ns |
| tras_ns | output | 8 | Minimum row active time, ns |
| self_refresh | output | 1 | Self refresh supported |
| refresh_code | output | 7 | Refresh interval code |
| cl_support | output | 8 | Supported CAS latency mask |
| cas_lat | output | 2 | Selected CAS latency |

## Verification
The hardest case to reach from the ports is a `start` pulse that lands while a fetch is under way and while the responder is stalling. The stimulus pulses `start` part-way through a slow fetch. The reference model then expects the address walk and the final results to be unchanged.

Acknowledge timing alternates between back-to-back acknowledges and gaps that depend on the address, so both the hold and the advance paths are exercised. The images include three cases:
- a checksum that is off by one;
- a correct checksum over a wrong type code;
- a CL2 cycle time exactly equal to the target period, which is the boundary of the CL2 rule.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 16;

  localparam logic [BYTE_W-1:0] ECC_CODE = 8'h02;

  // field slots captured by the decoder
  localparam int F_TYPE   = 0;
  localparam int F_ROWS   = 1;
  localparam int F_COLS   = 2;
  localparam int F_RANKS  = 3;
  localparam int F_WID_LO = 4;
  localparam int F_WID_HI = 5;
  localparam int F_TCK3   = 6;
  localparam int F_TAC3   = 7;
  localparam int F_CFG    = 8;
  localparam int F_REFR   = 9;
  localparam int F_CLMASK = 10;
  localparam int F_TCK2   = 11;
  localparam int F_TAC2   = 12;
  localparam int F_TRP    = 13;
  localparam int F_TRCD   = 14;
  localparam int F_TRAS   = 15;

  typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] field_vec_t;

  // byte address within the image for each field slot
  function automatic int field_ofs(input int slot);
    case (slot)
      F_TYPE:   return 2;
      F_ROWS:   return 3;
      F_COLS:   return 4;
      F_RANKS:  return 5;
      F_WID_LO: return 6;
      F_WID_HI: return 7;
      F_TCK3:   return 9;
      F_TAC3:   return 10;
      F_CFG:    return 11;
      F_REFR:   return 12;
      F_CLMASK: return 18;
      F_TCK2:   return 23;
      F_TAC2:   return 24;
      F_TRP:    return 27;
      F_TRCD:   return 29;
      default:  return 30;
    endcase
  endfunction
endpackage

// File: rtl/spd_fetch.sv
// Address sequencer: one outstanding byte request, ascending order.
module spd_fetch #(
  parameter int NUM_BYTES = 64,
  localparam int ADDR_W = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_ack,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              launch,
  output logic              take,
  output logic              last_take
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

  assign launch    = start && !busy;
  assign take      = busy && rd_ack;
  assign last_take = take && (addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (last_take) begin
      busy <= 1'b0;
    end else if (take) begin
      addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/spd_sum.sv
// Running modulo-2^W sum of the bytes that precede the checksum byte.
module spd_sum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         add,
  input  logic [W-1:0] data,
  output logic [W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (rst || clear) sum <= '0;
    else if (add)     sum <= sum + data;
  end
endmodule

// File: rtl/spd_decode.sv
// One capture register per decoded field, loaded when its address arrives.
module spd_decode import spd_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  output field_vec_t        fields
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(field_ofs(g));
    always_ff @(posedge clk) begin
      if (rst || clear)           fields[g] <= '0;
      else if (we && addr == OFS) fields[g] <= data;
    end
  end
endmodule

// File: rtl/spd_parser.sv
module spd_parser import spd_pkg::*; #(
  parameter int NUM_BYTES = 64,
  parameter logic [7:0] TYPE_CODE = 8'h04,
  localparam int ADDR_W = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        target_tck,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic [7:0]        row_count,
  output logic [7:0]        col_count,
  output logic [7:0]        rank_count,
  output logic [15:0]       data_width,
  output logic              ecc_en,
  output logic [7:0]        tck_cl3,
  output logic [7:0]        tac_cl3,
  output logic [7:0]        tck_cl2,
  output logic [7:0]        tac_cl2,
  output logic [7:0]        trp_ns,
  output logic [7:0]        trcd_ns,
  output logic [7:0]        tras_ns,
  output logic              self_refresh,
  output logic [6:0]        refresh_code,
  output logic [7:0]        cl_support,
  output logic [1:0]        cas_lat
);
  logic       busy, launch, take, last_take;
  logic [7:0] run_sum;
  field_vec_t fld;
  logic       cl2_ok, image_bad;

  spd_fetch #(.NUM_BYTES(NUM_BYTES)) u_fetch (
    .clk(clk), .rst(rst), .start(start), .rd_ack(rd_ack),
    .busy(busy), .addr(rd_addr), .launch(launch),
    .take(take), .last_take(last_take)
  );

  spd_sum #(.W(BYTE_W)) u_sum (
    .clk(clk), .rst(rst), .clear(launch),
    .add(take && !last_take), .data(rd_data), .sum(run_sum)
  );

  spd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .clear(launch), .we(take),
    .addr(rd_addr), .data(rd_data), .fields(fld)
  );

  assign rd_req    = busy;
  assign cl2_ok    = fld[F_CLMASK][1] && (fld[F_TCK2] <= target_tck);
  // on last_take, rd_data carries the stored checksum byte
  assign image_bad = (run_sum != rd_data) || (fld[F_TYPE] != TYPE_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      err          <= 1'b0;
      row_count    <= '0;
      col_count    <= '0;
      rank_count   <= '0;
      data_width   <= '0;
      ecc_en       <= 1'b0;
      tck_cl3      <= '0;
      tac_cl3      <= '0;
      tck_cl2      <= '0;
      tac_cl2      <= '0;
      trp_ns       <= '0;
      trcd_ns      <= '0;
      tras_ns      <= '0;
      self_refresh <= 1'b0;
      refresh_code <= '0;
      cl_support   <= '0;
      cas_lat      <= '0;
    end else if (launch) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else if (last_take) begin
      done         <= 1'b1;
      err          <= image_bad;
      row_count    <= fld[F_ROWS];
      col_count    <= fld[F_COLS];
      rank_count   <= fld[F_RANKS];
      data_width   <= {fld[F_WID_HI], fld[F_WID_LO]};
      ecc_en       <= (fld[F_CFG] == ECC_CODE);
      tck_cl3      <= fld[F_TCK3];
      tac_cl3      <= fld[F_TAC3];
      tck_cl2      <= fld[F_TCK2];
      tac_cl2      <= fld[F_TAC2];
      trp_ns       <= fld[F_TRP];
      trcd_ns      <= fld[F_TRCD];
      tras_ns      <= fld[F_TRAS];
      self_refresh <= fld[F_REFR][7];
      refresh_code <= fld[F_REFR][6:0];
      cl_support   <= fld[F_CLMASK];
      cas_lat      <= cl2_ok ? 2'd2 : 2'd3;
    end
  end
endmodule

// File: rtl/spd_parser_chk.sv
module spd_parser_chk #(
  parameter int NUM_BYTES = 64,
  localparam int ADDR_W = $clog2(NUM_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic              done,
  input logic              err,
  input logic [1:0]        cas_lat,
  input logic [7:0]        row_count,
  input logic [7:0]        tck_cl2
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    start && !rd_req |=> rd_req && rd_addr == '0 && !done && !err); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ack && rd_addr != LAST_ADDR |=> rd_req && rd_addr == $past(rd_addr) + 1'b1); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ack && rd_addr == LAST_ADDR |=> done && !rd_req); // R4
  AST_NO_REQ_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req); // R4
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R5
  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (cas_lat == 2'd2 || cas_lat == 2'd3)); // R10
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !(rd_ack && rd_addr == LAST_ADDR)
      |=> $stable(cas_lat) && $stable(row_count) && $stable(tck_cl2)); // R11
endmodule

bind spd_parser spd_parser_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_ack(rd_ack), .done(done), .err(err), .cas_lat(cas_lat),
  .row_count(row_count), .tck_cl2(tck_cl2)
);

// File: tb/test_spd_parser.sv
module test_spd_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  target_tck = 8'hA0;
  logic        rd_ack = 1'b0;
  logic [7:0]  rd_data = 8'hEE;
  logic        rd_req, done, err, ecc_en, self_refresh;
  logic [5:0]  rd_addr;
  logic [7:0]  row_count, col_count, rank_count, tck_cl3, tac_cl3, tck_cl2, tac_cl2;
  logic [7:0]  trp_ns, trcd_ns, tras_ns, cl_support;
  logic [15:0] data_width;
  logic [6:0]  refresh_code;
  logic [1:0]  cas_lat;

  spd_parser i_spd_parser (
    .clk(clk), .rst(rst), .start(start), .target_tck(target_tck),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .err(err), .row_count(row_count), .col_count(col_count),
    .rank_count(rank_count), .data_width(data_width), .ecc_en(ecc_en),
    .tck_cl3(tck_cl3), .tac_cl3(tac_cl3), .tck_cl2(tck_cl2), .tac_cl2(tac_cl2),
    .trp_ns(trp_ns), .trcd_ns(trcd_ns), .tras_ns(tras_ns),
    .self_refresh(self_refresh), .refresh_code(refresh_code),
    .cl_support(cl_support), .cas_lat(cas_lat)
  );

  always #4 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit cmp_on = 1'b0;
  bit slow = 1'b0;
  int wait_cnt = 0;
  logic [7:0] mem [64];

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_busy, m_done, m_err, m_ecc, m_sr;
  int m_addr;
  logic [7:0] m_row, m_col, m_rank, m_tck3, m_tac3, m_tck2, m_tac2, m_trp, m_trcd, m_tras, m_mask;
  logic [15:0] m_wid;
  logic [6:0] m_rc;
  logic [1:0] m_cl;

  task automatic model_finish();
    int s = 0;
    for (int i = 0; i < 63; i++) s += mem[i];
    m_err  = ((s % 256) != int'(mem[63])) || (mem[2] != 8'h04);
    m_row  = mem[3];  m_col = mem[4]; m_rank = mem[5];
    m_wid  = {mem[7], mem[6]};
    m_ecc  = (mem[11] == 8'h02);
    m_tck3 = mem[9];  m_tac3 = mem[10]; m_tck2 = mem[23]; m_tac2 = mem[24];
    m_trp  = mem[27]; m_trcd = mem[29]; m_tras = mem[30];
    m_sr   = mem[12][7]; m_rc = mem[12][6:0]; m_mask = mem[18];
    m_cl   = (mem[18][1] && mem[23] <= target_tck) ? 2'd2 : 2'd3;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_err = 0; m_addr = 0; m_ecc = 0; m_sr = 0;
      m_row = 0; m_col = 0; m_rank = 0; m_tck3 = 0; m_tac3 = 0; m_tck2 = 0; m_tac2 = 0;
      m_trp = 0; m_trcd = 0; m_tras = 0; m_mask = 0; m_wid = 0; m_rc = 0; m_cl = 0;
    end else if (start && !m_busy) begin
      m_busy = 1; m_addr = 0; m_done = 0; m_err = 0;
    end else if (m_busy && rd_ack) begin
      if (m_addr == 63) begin
        m_busy = 0; m_done = 1; model_finish();
      end else m_addr++;
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) if (cmp_on) begin
    check(rd_req === m_busy, "R3 request line", 64'(rd_req), 64'(m_busy));
    if (m_busy) check(rd_addr === 6'(m_addr), "R3 request address", 64'(rd_addr), 64'(m_addr));
    check(done === m_done, "R4 done flag", 64'(done), 64'(m_done));
    check(err === m_err, "R5 R6 error flag", 64'(err), 64'(m_err));
    check({row_count, col_count, rank_count, data_width, ecc_en} === {m_row, m_col, m_rank, m_wid, m_ecc},
          "R7 geometry (R11 hold)", 64'({row_count, col_count, rank_count, data_width, ecc_en}),
          64'({m_row, m_col, m_rank, m_wid, m_ecc}));
    check({tck_cl3, tac_cl3, tck_cl2, tac_cl2, trp_ns, trcd_ns, tras_ns} ===
          {m_tck3, m_tac3, m_tck2, m_tac2, m_trp, m_trcd, m_tras}, "R8 timing (R11 hold)",
          64'({tck_cl3, tac_cl3, tck_cl2, tac_cl2, trp_ns, trcd_ns, tras_ns}),
          64'({m_tck3, m_tac3, m_tck2, m_tac2, m_trp, m_trcd, m_tras}));
    check({self_refresh, refresh_code, cl_support} === {m_sr, m_rc, m_mask}, "R9 refresh and mask",
          64'({self_refresh, refresh_code, cl_support}), 64'({m_sr, m_rc, m_mask}));
    check(cas_lat === m_cl, "R10 cas latency (R11 hold)", 64'(cas_lat), 64'(m_cl));
  end

  // EEPROM responder
  always @(negedge clk) begin
    if (rst || rd_req !== 1'b1) begin
      rd_ack = 1'b0; rd_data = 8'hEE; wait_cnt = 0;
    end else if (wait_cnt == 0) begin
      rd_ack = 1'b1; rd_data = mem[rd_addr];
      wait_cnt = slow ? (int'(rd_addr) % 3) : 0;
    end else begin
      rd_ack = 1'b0; rd_data = 8'hEE; wait_cnt--;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    nerr++; nchk++;
    $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
    summary();
  end

  task automatic build_image(input logic [7:0] mtype, input bit ecc72, input logic [7:0] mask,
                             input logic [7:0] tck2, input bit bad_sum);
    int s = 0;
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 11) % 256);
    mem[2] = mtype; mem[3] = 8'h0D; mem[4] = 8'h0A; mem[5] = 8'h02;
    mem[6] = ecc72 ? 8'h48 : 8'h40; mem[7] = 8'h00;
    mem[9] = 8'h75; mem[10] = 8'h54; mem[11] = ecc72 ? 8'h02 : 8'h00; mem[12] = 8'h82;
    mem[18] = mask; mem[23] = tck2; mem[24] = 8'h60; mem[25] = 8'hFF; mem[26] = 8'hFF;
    mem[27] = 8'h14; mem[29] = 8'h14; mem[30] = 8'h2D;
    for (int i = 0; i < 63; i++) s += mem[i];
    mem[63] = 8'(s + (bad_sum ? 1 : 0));
  endtask

  task automatic run_parse(input logic [7:0] tgt, input bit slw, input bit poke, input logic [1:0] hold_cl);
    @(negedge clk);
    target_tck = tgt; slow = slw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 1000 && done !== 1'b1; n++) begin
      @(negedge clk);
      start = (poke && n == 12);
      if (n == 5 && hold_cl != 0)
        check(cas_lat === hold_cl, "R11 latency held during fetch", 64'(cas_lat), 64'(hold_cl));
    end
    start = 1'b0;
    check(done === 1'b1, "R4 done after fetch", 64'(done), 64'd1);
  endtask

  initial begin
    build_image(8'h04, 1'b0, 8'h06, 8'hA0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R1 reset state
    check({rd_req, done, err, cas_lat, row_count, data_width, tck_cl2} === '0, "R1 reset state",
          64'({rd_req, done, err, cas_lat, row_count, data_width, tck_cl2}), 64'd0);
    repeat (2) @(negedge clk);

    // target equals CL2 cycle time: boundary picks CL2
    run_parse(8'hA0, 1'b0, 1'b0, 2'd0);
    check(cas_lat === 2'd2, "R10 boundary picks CL2", 64'(cas_lat), 64'd2);
    check(err === 1'b0, "R5 good image", 64'(err), 64'd0);
    check(data_width === 16'h0040 && ecc_en === 1'b0, "R7 64-bit no ECC", 64'({data_width, ecc_en}), 64'h80);
    check({row_count, col_count, rank_count} === 24'h0D0A02, "R7 geometry", 64'({row_count, col_count, rank_count}), 64'h0D0A02);
    check(tck_cl3 === 8'h75 && tras_ns === 8'h2D, "R8 timing fields", 64'({tck_cl3, tras_ns}), 64'h752D);
    check(self_refresh === 1'b1 && refresh_code === 7'h02, "R9 refresh fields", 64'({self_refresh, refresh_code}), 64'h82);

    // target below CL2 time, slow responder, start poked mid-fetch
    run_parse(8'h99, 1'b1, 1'b1, 2'd2);
    check(cas_lat === 2'd3, "R10 faster target picks CL3", 64'(cas_lat), 64'd3);
    check(err === 1'b0, "R2 mid-fetch start ignored", 64'(err), 64'd0);

    // ECC module, CL2 not in mask
    build_image(8'h04, 1'b1, 8'h04, 8'hA0, 1'b0);
    run_parse(8'hFF, 1'b1, 1'b0, 2'd0);
    check(cas_lat === 2'd3, "R10 mask without CL2", 64'(cas_lat), 64'd3);
    check(data_width === 16'h0048 && ecc_en === 1'b1, "R7 72-bit ECC", 64'({data_width, ecc_en}), 64'h91);

    // checksum off by one
    build_image(8'h04, 1'b0, 8'h06, 8'hA0, 1'b1);
    run_parse(8'hA0, 1'b0, 1'b0, 2'd0);
    check(err === 1'b1, "R5 bad checksum flagged", 64'(err), 64'd1);

    // wrong memory type, correct checksum
    build_image(8'h02, 1'b0, 8'h06, 8'hA0, 1'b0);
    run_parse(8'hA0, 1'b1, 1'b0, 2'd0);
    check(err === 1'b1, "R6 wrong type flagged", 64'(err), 64'd1);

    // new start clears done and err
    build_image(8'h04, 1'b0, 8'h06, 8'hA0, 1'b0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done === 1'b0 && err === 1'b0, "R2 start clears flags", 64'({done, err}), 64'd0);
    for (int n = 0; n < 1000 && done !== 1'b1; n++) @(negedge clk);
    check(done === 1'b1 && err === 1'b0, "R4 R5 clean rerun", 64'({done, err}), 64'h2);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule